// File: doc/BRIEF.md
# Stereo Audio Sample FIFO Register Port

This block sits between a processor bus and a stereo codec sample stream. Each direction has two FIFOs, one per channel. Captured samples from the codec are queued until software reads them. Samples that software writes are queued until the codec side takes them. Software sees four 32-bit word registers, selected by a two-bit word index: a control/status word, a packed occupancy word, a left data word and a right data word.

A read of a data word returns the head of that channel's input FIFO and removes it. A write to a data word appends to that channel's output FIFO. Two pending flags drive a level-sensitive interrupt. One flag reports an input FIFO at or above three quarters full. The other reports an output FIFO below one quarter full. Each of the two clear bits empties both FIFOs of one direction, and the clear stays in force for as long as the bit remains set.

On the codec side, a valid strobe pushes one sample pair into the input FIFOs. The output FIFOs offer a sample pair with a valid/ready handshake, and that pair is popped from both channels together.

Top module: `stereo_fifo_port`

## Requirements
- R1: After reset, the occupancy word (index 1) reads 0x8080_0000. Its fields are: right-input word count in bits 7:0, left-input word count in bits 15:8, right-output free slots in bits 23:16 and left-output free slots in bits 31:24. Each FIFO holds 128 words.
- R2: The control word (index 0) has these bits: bit 0 is the receive-interrupt enable, bit 1 the transmit-interrupt enable, bit 2 the input clear and bit 3 the output clear. Bit 8 is receive-pending and bit 9 is transmit-pending, and both are read-only. All other bits read 0. After reset the control word reads 0x0000_0200.
- R3: When cin_valid is high on a clock edge, cin_left and cin_right are appended to the left and right input FIFOs. A push into a full input FIFO is dropped, and cin_ready is low while either input FIFO is full.
- R4: A read of index 2 (left) or index 3 (right) returns that channel's oldest input word and pops it. A read of an empty input FIFO returns 0 and leaves the count at 0.
- R5: A write to index 2 or index 3 appends to the left or right output FIFO. A write to a full output FIFO is dropped. cout_valid is high when both output FIFOs hold data, and a cycle with cout_valid and cout_ready high pops one word from each.
- R6: Receive-pending becomes 1 one cycle after either input FIFO holds 96 or more words. It becomes 0 one cycle after both input FIFOs hold fewer than 96.
- R7: Transmit-pending becomes 1 one cycle after either output FIFO holds fewer than 32 words. It becomes 0 one cycle after both output FIFOs hold more than 32. Otherwise it keeps its value.
- R8: irq is high exactly when receive-pending is set together with its enable, or transmit-pending is set together with its enable.
- R9: While the input clear bit is set, both input FIFOs are emptied on every cycle and codec pushes are lost. While the output clear bit is set, the same holds for the output FIFOs and bus writes to the data words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 2 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops on data words) |
| bus_rdata | output | 32 | Read data, combinational from bus_word |
| irq | output | 1 | Level interrupt |
| cin_valid | input | 1 | Codec capture sample pair valid |
| cin_left | input | 32 | Captured left sample |
| cin_right | input | 32 | Captured right sample |
| cin_ready | output | 1 | Both input FIFOs have room |
| cout_valid | output | 1 | Playback sample pair available |
| cout_left | output | 32 | Left playback sample |
| cout_right | output | 32 | Right playback sample |
| cout_ready | input | 1 | Codec takes the playback pair |

## Verification
Read data is combinational, so the bench samples bus_rdata in the low phase of the cycle that carries the read strobe, before the edge that pops. FIFO counts change on the edge that accepts a push or a pop. The clear bits and the pending flags are registered, so a clear or a flag change lands one edge after the cause. Every check that follows a control write or a count change therefore waits three edges before sampling, and edge-exact timing is left to the clocked properties in the RTL.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam int DATA_W = 32;
   localparam int FIELD_W = 8;
   typedef enum logic [1:0] {
      W_CTRL  = 2'd0,
      W_SPACE = 2'd1,
      W_LEFT  = 2'd2,
      W_RIGHT = 2'd3
   } word_e;
   localparam int B_RX_EN   = 0;
   localparam int B_TX_EN   = 1;
   localparam int B_CLR_IN  = 2;
   localparam int B_CLR_OUT = 3;
   localparam int B_RX_PEND = 8;
   localparam int B_TX_PEND = 9;
   typedef enum logic {
      LVL_HIGH = 1'b0,
      LVL_LOW  = 1'b1
   } lvl_mode_e;
endpackage

// File: rtl/sfr_fifo.sv
module sfr_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 128,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("sfr_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign do_push = push && !clr && (count != CNT_W'(DEPTH));
   assign do_pop  = pop && !clr && (count != '0);
   assign dout    = (count != '0) ? mem[rd_ptr] : '0;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && !pop && !clr) |=> count == CNT_W'(DEPTH));
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push) |=> count == '0);
   p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
endmodule

// File: rtl/sfr_level_flag.sv
module sfr_level_flag
   import sfr_pkg::*;
#(
   parameter int        CNT_W = 8,
   parameter int        LEVEL = 96,
   parameter lvl_mode_e MODE  = LVL_HIGH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_a,
   input  logic [CNT_W-1:0] cnt_b,
   output logic             pend
);
   localparam logic [CNT_W-1:0] LV = CNT_W'(LEVEL);
   localparam logic RST_VAL = (MODE == LVL_LOW) ? (LEVEL > 0) : 1'b0;

   logic set_c, clr_c;

   if (MODE == LVL_HIGH) begin : g_high
      assign set_c = (cnt_a >= LV) || (cnt_b >= LV);
      assign clr_c = (cnt_a < LV) && (cnt_b < LV);
      p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ((cnt_a >= LV) || (cnt_b >= LV)) |=> pend);
      p_rx_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ((cnt_a < LV) && (cnt_b < LV)) |=> !pend);
   end else begin : g_low
      assign set_c = (cnt_a < LV) || (cnt_b < LV);
      assign clr_c = (cnt_a > LV) && (cnt_b > LV);
      p_tx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ((cnt_a < LV) || (cnt_b < LV)) |=> pend);
      p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_a >= LV && cnt_b >= LV && !(cnt_a > LV && cnt_b > LV)) |=> $stable(pend));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     pend <= RST_VAL;
      else if (set_c) pend <= 1'b1;
      else if (clr_c) pend <= 1'b0;
   end
endmodule

// File: rtl/stereo_fifo_port.sv
module stereo_fifo_port
   import sfr_pkg::*;
#(
   parameter int DEPTH  = 128,
   parameter int RX_PCT = 75,
   parameter int TX_PCT = 25,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int RX_LV = DEPTH * RX_PCT / 100,
   localparam int TX_LV = DEPTH * TX_PCT / 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_word,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              cin_valid,
   input  logic [DATA_W-1:0] cin_left,
   input  logic [DATA_W-1:0] cin_right,
   output logic              cin_ready,
   output logic              cout_valid,
   output logic [DATA_W-1:0] cout_left,
   output logic [DATA_W-1:0] cout_right,
   input  logic              cout_ready
);
   if (CNT_W > FIELD_W) begin : g_bad_width
      $error("stereo_fifo_port: DEPTH too large for occupancy fields");
   end

   localparam int NCH = 4;
   localparam int IN_L = 0, IN_R = 1, OUT_L = 2, OUT_R = 3;

   logic rx_en, tx_en, clr_in, clr_out;
   logic rx_pend, tx_pend;
   logic [NCH-1:0]        f_push, f_pop, f_clr;
   logic [DATA_W-1:0]     f_din  [NCH];
   logic [DATA_W-1:0]     f_dout [NCH];
   logic [CNT_W-1:0]      f_cnt  [NCH];
   logic                  cout_take;

   assign cout_take = cout_valid && cout_ready;

   assign f_push[IN_L]  = cin_valid;
   assign f_push[IN_R]  = cin_valid;
   assign f_push[OUT_L] = bus_wr && (bus_word == W_LEFT);
   assign f_push[OUT_R] = bus_wr && (bus_word == W_RIGHT);
   assign f_pop[IN_L]   = bus_rd && (bus_word == W_LEFT);
   assign f_pop[IN_R]   = bus_rd && (bus_word == W_RIGHT);
   assign f_pop[OUT_L]  = cout_take;
   assign f_pop[OUT_R]  = cout_take;
   assign f_din[IN_L]   = cin_left;
   assign f_din[IN_R]   = cin_right;
   assign f_din[OUT_L]  = bus_wdata;
   assign f_din[OUT_R]  = bus_wdata;
   assign f_clr         = {clr_out, clr_out, clr_in, clr_in};

   for (genvar i = 0; i < NCH; i++) begin : g_fifo
      sfr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (f_clr[i]),
         .push  (f_push[i]),
         .din   (f_din[i]),
         .pop   (f_pop[i]),
         .dout  (f_dout[i]),
         .count (f_cnt[i])
      );
   end

   sfr_level_flag #(.CNT_W(CNT_W), .LEVEL(RX_LV), .MODE(LVL_HIGH)) u_rx_flag (
      .clk (clk), .rst_n (rst_n),
      .cnt_a (f_cnt[IN_L]), .cnt_b (f_cnt[IN_R]), .pend (rx_pend));
   sfr_level_flag #(.CNT_W(CNT_W), .LEVEL(TX_LV), .MODE(LVL_LOW)) u_tx_flag (
      .clk (clk), .rst_n (rst_n),
      .cnt_a (f_cnt[OUT_L]), .cnt_b (f_cnt[OUT_R]), .pend (tx_pend));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en <= 1'b0; tx_en <= 1'b0; clr_in <= 1'b0; clr_out <= 1'b0;
      end else if (bus_wr && bus_word == W_CTRL) begin
         rx_en   <= bus_wdata[B_RX_EN];
         tx_en   <= bus_wdata[B_TX_EN];
         clr_in  <= bus_wdata[B_CLR_IN];
         clr_out <= bus_wdata[B_CLR_OUT];
      end
   end

   logic [DATA_W-1:0] ctrl_word, space_word;
   always_comb begin
      ctrl_word = '0;
      ctrl_word[B_RX_EN]   = rx_en;
      ctrl_word[B_TX_EN]   = tx_en;
      ctrl_word[B_CLR_IN]  = clr_in;
      ctrl_word[B_CLR_OUT] = clr_out;
      ctrl_word[B_RX_PEND] = rx_pend;
      ctrl_word[B_TX_PEND] = tx_pend;
   end
   assign space_word = {FIELD_W'(CNT_W'(DEPTH) - f_cnt[OUT_L]),
                        FIELD_W'(CNT_W'(DEPTH) - f_cnt[OUT_R]),
                        FIELD_W'(f_cnt[IN_L]),
                        FIELD_W'(f_cnt[IN_R])};

   always_comb begin
      case (word_e'(bus_word))
         W_CTRL:  bus_rdata = ctrl_word;
         W_SPACE: bus_rdata = space_word;
         W_LEFT:  bus_rdata = f_dout[IN_L];
         default: bus_rdata = f_dout[IN_R];
      endcase
   end

   assign irq        = (rx_pend && rx_en) || (tx_pend && tx_en);
   assign cin_ready  = (f_cnt[IN_L] != CNT_W'(DEPTH)) && (f_cnt[IN_R] != CNT_W'(DEPTH));
   assign cout_valid = (f_cnt[OUT_L] != '0) && (f_cnt[OUT_R] != '0);
   assign cout_left  = f_dout[OUT_L];
   assign cout_right = f_dout[OUT_R];

   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !tx_en) |-> !irq);
   p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rx_pend) |-> irq);
   p_clr_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_in |=> (f_cnt[IN_L] == '0 && f_cnt[IN_R] == '0));
   p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_word == W_CTRL) |-> (bus_rdata[31:10] == '0 && bus_rdata[7:4] == '0));
endmodule

// File: tb/stereo_fifo_port_tb.sv
module stereo_fifo_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_word = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        cin_valid = 1'b0;
   logic [31:0] cin_left = '0, cin_right = '0;
   logic        cin_ready, cout_valid;
   logic [31:0] cout_left, cout_right;
   logic        cout_ready = 1'b0;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   stereo_fifo_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
      .cin_valid(cin_valid), .cin_left(cin_left), .cin_right(cin_right),
      .cin_ready(cin_ready), .cout_valid(cout_valid), .cout_left(cout_left),
      .cout_right(cout_right), .cout_ready(cout_ready));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] w, input logic [31:0] d);
      @(negedge clk);
      bus_word = w; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] w, output logic [31:0] d);
      @(negedge clk);
      bus_word = w; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic cpush(input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cin_valid = 1'b1; cin_left = base + i; cin_right = base + 32'h100 + i;
         @(posedge clk); #1;
         cin_valid = 1'b0;
      end
   endtask

   task automatic cpop(output logic [31:0] l, output logic [31:0] r);
      @(negedge clk);
      l = cout_left; r = cout_right; cout_ready = 1'b1;
      @(posedge clk); #1;
      cout_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(2'd1, d); chk("R1 space after reset", d, 32'h8080_0000);
      rd(2'd0, d); chk("R2 ctrl after reset", d, 32'h0000_0200);
      chk("R8 irq after reset", {31'b0, irq}, 32'd0);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      wr(2'd0, 32'hFFFF_F0F3); settle();
      rd(2'd0, d); chk("R2 ctrl readback", d, 32'h0000_0203);
      chk("R8 irq with tx enable", {31'b0, irq}, 32'd1);
      wr(2'd0, 32'h0); settle();
      chk("R8 irq masked", {31'b0, irq}, 32'd0);
   endtask

   task automatic t_rx_basic();
      logic [31:0] d;
      cpush(3, 32'h10); settle();
      rd(2'd1, d); chk("R3 counts after 3 pushes", d, 32'h8080_0303);
      rd(2'd2, d); chk("R4 left head 0", d, 32'h10);
      rd(2'd2, d); chk("R4 left head 1", d, 32'h11);
      rd(2'd3, d); chk("R4 right head 0", d, 32'h110);
      rd(2'd2, d); chk("R4 left head 2", d, 32'h12);
      rd(2'd2, d); chk("R4 empty read zero", d, 32'h0);
      rd(2'd1, d); chk("R4 counts after pops", d, 32'h8080_0002);
      wr(2'd0, 32'h4); wr(2'd0, 32'h0); settle();
      rd(2'd1, d); chk("R9 input clear", d, 32'h8080_0000);
   endtask

   task automatic t_rx_full();
      logic [31:0] d;
      cpush(130, 32'h1000); settle();
      rd(2'd1, d); chk("R3 full input counts", d, 32'h8080_8080);
      chk("R3 cin_ready low when full", {31'b0, cin_ready}, 32'd0);
      rd(2'd2, d); chk("R3 overflow dropped, head kept", d, 32'h1000);
      wr(2'd0, 32'h4); settle();
      rd(2'd1, d); chk("R9 clear empties input", d, 32'h8080_0000);
      cpush(2, 32'h2000); settle();
      rd(2'd1, d); chk("R9 push lost while clear held", d, 32'h8080_0000);
      wr(2'd0, 32'h0); settle();
   endtask

   task automatic t_rx_irq();
      logic [31:0] d;
      cpush(95, 32'h0); settle();
      rd(2'd0, d); chk("R6 no pend at 95", d & 32'h100, 32'h0);
      cpush(1, 32'h0); settle();
      rd(2'd0, d); chk("R6 pend at 96", d & 32'h100, 32'h100);
      chk("R8 irq off with enable 0", {31'b0, irq}, 32'd0);
      wr(2'd0, 32'h1); settle();
      chk("R8 irq on with rx enable", {31'b0, irq}, 32'd1);
      rd(2'd2, d); settle();
      chk("R6 still pending, right at 96", {31'b0, irq}, 32'd1);
      rd(2'd3, d); settle();
      rd(2'd0, d); chk("R6 pend cleared both 95", d & 32'h100, 32'h0);
      chk("R8 irq drops", {31'b0, irq}, 32'd0);
      wr(2'd0, 32'h4); wr(2'd0, 32'h0); settle();
   endtask

   task automatic t_tx();
      logic [31:0] d, l, r;
      for (int i = 0; i < 32; i++) begin
         wr(2'd2, 32'hA000 + i); wr(2'd3, 32'hB000 + i);
      end
      settle();
      rd(2'd1, d); chk("R5 output free at 32", d, 32'h6060_0000);
      rd(2'd0, d); chk("R7 pend held at 32", d & 32'h200, 32'h200);
      wr(2'd2, 32'hA020); wr(2'd3, 32'hB020); settle();
      rd(2'd0, d); chk("R7 pend clears above 32", d & 32'h200, 32'h0);
      chk("R5 cout_valid", {31'b0, cout_valid}, 32'd1);
      cpop(l, r);
      chk("R5 cout left order", l, 32'hA000);
      chk("R5 cout right order", r, 32'hB000);
      settle();
      rd(2'd0, d); chk("R7 pend held low at 32", d & 32'h200, 32'h0);
      cpop(l, r); settle();
      rd(2'd0, d); chk("R7 pend sets below 32", d & 32'h200, 32'h200);
      wr(2'd0, 32'h2); settle();
      chk("R8 irq tx", {31'b0, irq}, 32'd1);
      for (int i = 0; i < 98; i++) wr(2'd2, 32'hC000 + i);
      settle();
      rd(2'd1, d); chk("R5 left full, extra dropped", d, 32'h0061_0000);
      wr(2'd0, 32'h8); settle();
      wr(2'd3, 32'h5); settle();
      rd(2'd1, d); chk("R9 output clear held", d, 32'h8080_0000);
      wr(2'd0, 32'h0); settle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      t_reset();
      t_ctrl();
      t_rx_basic();
      t_rx_full();
      t_rx_irq();
      t_tx();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule